// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a cycle-accurate, synthesizable model of a synchronous static memory whose write data trails its command by the same two cycles that read data trails a read. Because both directions use the same slot on the data bus, a host can issue reads and writes in any mix on consecutive clocks and never insert an idle cycle to turn the bus around.

Commands, addresses and byte enables are captured on each enabled rising edge. A pending-write pipeline holds each write's address and lanes until its data arrives. Reads look up the array one stage after their command. They pick up, lane by lane, any write whose data lands on that same edge. A four-beat burst engine can replay the last command on a wrapped address sequence, in linear or interleaved order. A clock-enable pin freezes the whole core. Three chip enables start a deselect that lets work already in flight finish. The array depth is small so that the model fits in a bench.

Top module: `ntsram_core`

## Requirements
- R1: While `rstN` is low at a rising edge, the pipeline empties: afterwards `dataOe` is 0 and `dataOut` is 0, including when a read was in flight.
- R2: With `rdWrN` high (read) at enabled edge E, the addressed word is on `dataOut` with `dataOe` high from enabled edge E+1 until enabled edge E+2, so the host captures it at E+2.
- R3: With `rdWrN` low (write) at enabled edge E, the address and byte enables are taken at E. The word is sampled from `dataIn` at enabled edge E+2 and is readable from then on.
- R4: `byteWrN` is active low per lane: bit 0 gates data bits 8:0 and bit 1 gates bits 17:9. A lane whose enable is high keeps its old contents. Both bits low write all 18 bits.
- R5: Reads and writes run back to back in any order. A read whose array lookup coincides with the data edge of an earlier write to the same address returns that write's enabled lanes and the stored value of the other lanes.
- R6: With `burstAdv` high, `addr`, `chipEnN` and `rdWrN` are ignored. The previous command (read, write or deselect) repeats at the next burst address. Bursts are four beats and wrap within `addr[1:0]`, keeping the upper address bits.
- R7: `burstOrder` low gives linear beats (start offset plus beat count, modulo 4). High gives interleaved beats (start offset XOR beat count).
- R8: While `clkEnN` is high, every pipeline stage, the burst state, the array and the outputs hold. All other inputs at such edges are ignored, and only enabled edges count toward latencies.
- R9: Any `chipEnN` bit high with `burstAdv` low at edge E is a deselect. Commands before E still complete, and `dataOe` is low in the slot belonging to E.
- R10: `dataOe` is high only in a read's data slot and only while `outEnN` is low. `outEnN` high forces it low at once, and it is never high in a write or deselect slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low pipeline reset |
| clkEnN | input | 1 | Active-low clock enable; high stalls the core |
| chipEnN | input | 3 | Active-low chip enables; any bit high deselects |
| rdWrN | input | 1 | High read, low write |
| burstAdv | input | 1 | High: continue the burst with the previous command |
| burstOrder | input | 1 | Low linear, high interleaved burst order |
| byteWrN | input | 2 | Active-low lane write enables |
| addr | input | 6 | Word address |
| dataIn | input | 18 | Write data, sampled two enabled edges after its command |
| outEnN | input | 1 | Active-low output enable |
| dataOut | output | 18 | Read data |
| dataOe | output | 1 | Drive enable for `dataOut` |

## Verification
The burst-step assertion assumes that `burstOrder` stays steady for the whole of a burst and that no stall falls between burst beats. The bench only changes the order pin on a cycle where `burstAdv` is low, and it stalls only outside bursts. The deselect and read-slot properties assume that `outEnN` and the control inputs change only between clock edges. The bench drives every input one nanosecond after a rising edge. It also reads back only addresses it has already written, because the array has no reset value.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             advance;
    logic             memWe;
    logic             rdLoad;
    logic [LANES-1:0] wrLanes;
    logic [LANES-1:0] fwdLanes;
  } strobe_t;
endpackage

// File: rtl/ntsram_ctrl.sv
module ntsram_ctrl
  import ntsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int NUM_CE  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic [NUM_CE-1:0] chipEnN,
  input  logic              rdWrN,
  input  logic              burstAdv,
  input  logic              burstOrder,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int HI_W = ADDR_W - BURST_W;

  cmd_e              s1Cmd, s2Cmd, nxtCmd;
  logic [ADDR_W-1:0] s1Addr, s2Addr, nxtAddr;
  logic [LANES-1:0]  s1Lanes, s2Lanes;
  logic [HI_W-1:0]   baseHi, nxtBaseHi;
  logic [BURST_W-1:0] startOff, beat, nxtStart, nxtBeat, nxtLow;

  // command decode and burst address generation
  always_comb begin
    if (burstAdv) begin
      nxtCmd    = s1Cmd;
      nxtBaseHi = baseHi;
      nxtStart  = startOff;
      nxtBeat   = beat + BURST_W'(1);
    end else begin
      nxtCmd    = (|chipEnN) ? CMD_IDLE : (rdWrN ? CMD_READ : CMD_WRITE);
      nxtBaseHi = addr[ADDR_W-1:BURST_W];
      nxtStart  = addr[BURST_W-1:0];
      nxtBeat   = '0;
    end
    nxtLow  = burstOrder ? (nxtStart ^ nxtBeat) : (nxtStart + nxtBeat);
    nxtAddr = {nxtBaseHi, nxtLow};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Cmd    <= CMD_IDLE;
      s2Cmd    <= CMD_IDLE;
      s1Addr   <= '0;
      s2Addr   <= '0;
      s1Lanes  <= '0;
      s2Lanes  <= '0;
      baseHi   <= '0;
      startOff <= '0;
      beat     <= '0;
    end else if (!clkEnN) begin
      s1Cmd    <= nxtCmd;
      s1Addr   <= nxtAddr;
      s1Lanes  <= ~byteWrN;
      s2Cmd    <= s1Cmd;
      s2Addr   <= s1Addr;
      s2Lanes  <= s1Lanes;
      baseHi   <= nxtBaseHi;
      startOff <= nxtStart;
      beat     <= nxtBeat;
    end
  end

  always_comb begin
    strb.advance  = !clkEnN;
    strb.memWe    = (s2Cmd == CMD_WRITE);
    strb.rdLoad   = (s1Cmd == CMD_READ);
    strb.wrLanes  = s2Lanes;
    strb.fwdLanes = (strb.memWe && (s2Addr == s1Addr)) ? s2Lanes : '0;
  end

  assign wrAddr = s2Addr;
  assign rdAddr = s1Addr;
endmodule

// File: rtl/ntsram_dpath.sv
module ntsram_dpath
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int LANE_W = WORD_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];
  logic [LANES-1:0][LANE_W-1:0] inLanes, rdLanes;
  logic [WORD_W-1:0]            outQ;
  logic                         oeQ;

  assign inLanes = dataIn;

  // per-lane choice between the array and a write landing this edge
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rdLanes[g] = strb.fwdLanes[g] ? inLanes[g] : mem[rdAddr][g];
  end

  always_ff @(posedge clk) begin
    if (strb.advance && strb.memWe) begin
      for (int l = 0; l < LANES; l++) begin
        if (strb.wrLanes[l]) mem[wrAddr][l] <= inLanes[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeQ  <= 1'b0;
      outQ <= '0;
    end else if (strb.advance) begin
      oeQ <= strb.rdLoad;
      if (strb.rdLoad) outQ <= rdLanes;
    end
  end

  assign dataOut = outQ;
  assign dataOe  = oeQ & ~outEnN;
endmodule

// File: rtl/ntsram_core.sv
module ntsram_core
  import ntsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 18,
  parameter int BURST_W = 2,
  parameter int NUM_CE  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic [NUM_CE-1:0] chipEnN,
  input  logic              rdWrN,
  input  logic              burstAdv,
  input  logic              burstOrder,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOe
);
  strobe_t           strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  ntsram_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .NUM_CE(NUM_CE)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .chipEnN(chipEnN),
    .rdWrN(rdWrN), .burstAdv(burstAdv), .burstOrder(burstOrder),
    .byteWrN(byteWrN), .addr(addr), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  ntsram_dpath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .dataIn(dataIn), .outEnN(outEnN),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/ntsram_chk.sv
module ntsram_chk #(
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 18,
  parameter int BURST_W = 2,
  parameter int NUM_CE  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic [NUM_CE-1:0] chipEnN,
  input logic              burstAdv,
  input logic              burstOrder,
  input logic              outEnN,
  input logic [WORD_W-1:0] dataOut,
  input logic              dataOe,
  input logic              rdLoad,
  input logic [ADDR_W-1:0] rdAddr
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(dataOut));

  // R9
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && $past(!clkEnN && !burstAdv && (|chipEnN))) |=> !dataOe);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && rdLoad) |=> (dataOe || outEnN));

  // R6
  burst_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && burstAdv) |=> (rdLoad == $past(rdLoad)));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && burstAdv && !burstOrder && $past(!burstOrder)) |=>
      ((rdAddr[BURST_W-1:0] == BURST_W'($past(rdAddr[BURST_W-1:0]) + 1'b1)) &&
       (rdAddr[ADDR_W-1:BURST_W] == $past(rdAddr[ADDR_W-1:BURST_W]))));
endmodule

bind ntsram_core ntsram_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BURST_W(BURST_W), .NUM_CE(NUM_CE)
) u_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .chipEnN(chipEnN),
  .burstAdv(burstAdv), .burstOrder(burstOrder), .outEnN(outEnN),
  .dataOut(dataOut), .dataOe(dataOe), .rdLoad(strb.rdLoad), .rdAddr(rdAddr)
);

// File: tb/sim_ntsram_core.sv
`timescale 1ns/1ps
module sim_ntsram_core;
  logic        clk = 1'b0;
  logic        rstN;
  logic        clkEnN;
  logic [2:0]  chipEnN;
  logic        rdWrN;
  logic        burstAdv;
  logic        burstOrder;
  logic [1:0]  byteWrN;
  logic [5:0]  addr;
  logic [17:0] dataIn;
  logic        outEnN;
  logic [17:0] dataOut;
  logic        dataOe;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  ntsram_core u0 (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .chipEnN(chipEnN),
    .rdWrN(rdWrN), .burstAdv(burstAdv), .burstOrder(burstOrder),
    .byteWrN(byteWrN), .addr(addr), .dataIn(dataIn), .outEnN(outEnN),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  typedef struct packed {
    logic        desel;
    logic        rw;
    logic        adv;
    logic [1:0]  bw;
    logic [5:0]  a;
    logic [17:0] din;
    logic        expOe;
    logic [17:0] expD;
  } vec_t;

  // each row is applied at one edge; expectations hold right after it
  localparam vec_t TABLE [13] = '{
    '{1'b0, 1'b0, 1'b0, 2'b00, 6'h10, 18'h00000, 1'b0, 18'h00000}, // R3 write 0x10
    '{1'b0, 1'b0, 1'b0, 2'b00, 6'h11, 18'h00000, 1'b0, 18'h00000}, // R3 write 0x11
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'h10, 18'h12345, 1'b0, 18'h00000}, // R10 write slot
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'h11, 18'h2ABCD, 1'b1, 18'h12345}, // R2 read 0x10
    '{1'b0, 1'b0, 1'b0, 2'b10, 6'h11, 18'h00000, 1'b1, 18'h2ABCD}, // R5 write after read
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'h11, 18'h00000, 1'b0, 18'h00000}, // R10 write slot
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'h10, 18'h3FFFF, 1'b1, 18'h2ABFF}, // R4 R5 lane0 forward
    '{1'b1, 1'b1, 1'b0, 2'b00, 6'h10, 18'h00000, 1'b1, 18'h12345}, // R9 earlier read completes
    '{1'b0, 1'b0, 1'b0, 2'b01, 6'h11, 18'h00000, 1'b0, 18'h00000}, // R9 deselect slot
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'h11, 18'h00000, 1'b0, 18'h00000}, // R10 write slot
    '{1'b0, 1'b1, 1'b0, 2'b00, 6'h11, 18'h00000, 1'b1, 18'h001FF}, // R4 lane1 forward
    '{1'b1, 1'b1, 1'b0, 2'b00, 6'h00, 18'h00000, 1'b1, 18'h001FF}, // R3 committed word
    '{1'b1, 1'b1, 1'b0, 2'b00, 6'h00, 18'h00000, 1'b0, 18'h00000}  // R9
  };

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [2:0] ce, input logic rw,
                      input logic adv, input logic ord, input logic [1:0] bw,
                      input logic [5:0] a, input logic [17:0] d);
    clkEnN = ~en; chipEnN = ce; rdWrN = rw; burstAdv = adv;
    burstOrder = ord; byteWrN = bw; addr = a; dataIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  localparam logic [17:0] A0 = 18'h11111, A1 = 18'h22222,
                          A2 = 18'h33333, A3 = 18'h04444;

  initial begin
    rstN = 1'b0; clkEnN = 1'b0; chipEnN = 3'b111; rdWrN = 1'b1;
    burstAdv = 1'b0; burstOrder = 1'b0; byteWrN = 2'b11; addr = '0;
    dataIn = '0; outEnN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    chk("R1 oe after reset", 18'(dataOe), 18'd0);
    chk("R1 data after reset", dataOut, 18'd0);

    // vector table: interleaved reads and writes, lanes, forwarding
    for (int i = 0; i < 13; i++) begin
      step(1'b1, TABLE[i].desel ? 3'b010 : 3'b000, TABLE[i].rw, TABLE[i].adv,
           1'b0, TABLE[i].bw, TABLE[i].a, TABLE[i].din);
      chk($sformatf("R2 R10 table oe row %0d", i), 18'(dataOe), 18'(TABLE[i].expOe));
      if (TABLE[i].expOe)
        chk($sformatf("R5 table data row %0d", i), dataOut, TABLE[i].expD);
    end

    // R6 linear write burst from 0x22, junk on ignored pins
    step(1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 2'b00, 6'h22, 18'h0);
    step(1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 2'b00, 6'h3F, 18'h0);
    chk("R6 write burst slot", 18'(dataOe), 18'd0);
    step(1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 2'b00, 6'h3F, A0);
    step(1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 2'b00, 6'h3F, A1);
    chk("R6 write burst slot", 18'(dataOe), 18'd0);
    // R7 interleaved read burst from 0x21: 21,20,23,22
    step(1'b1, 3'b000, 1'b1, 1'b0, 1'b1, 2'b00, 6'h21, A2);
    step(1'b1, 3'b111, 1'b0, 1'b1, 1'b1, 2'b00, 6'h00, A3);
    chk("R7 beat0 0x21", dataOut, A3);
    chk("R6 beat0 oe", 18'(dataOe), 18'd1);
    step(1'b1, 3'b111, 1'b0, 1'b1, 1'b1, 2'b00, 6'h00, 18'h0);
    chk("R7 beat1 0x20", dataOut, A2);
    step(1'b1, 3'b111, 1'b0, 1'b1, 1'b1, 2'b00, 6'h00, 18'h0);
    chk("R7 beat2 0x23", dataOut, A1);
    step(1'b1, 3'b001, 1'b1, 1'b0, 1'b1, 2'b00, 6'h00, 18'h0);
    chk("R7 beat3 0x22", dataOut, A0);
    step(1'b1, 3'b100, 1'b1, 1'b0, 1'b0, 2'b00, 6'h00, 18'h0);
    chk("R9 after burst", 18'(dataOe), 18'd0);

    // R8 stall: read 0x22, then stalled edges carrying a write
    step(1'b1, 3'b000, 1'b1, 1'b0, 1'b0, 2'b00, 6'h22, 18'h0);
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 2'b00, 6'h22, 18'h3FFFF);
    chk("R8 stall holds oe", 18'(dataOe), 18'd0);
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 2'b00, 6'h22, 18'h3FFFF);
    chk("R8 stall holds oe", 18'(dataOe), 18'd0);
    step(1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 2'b00, 6'h00, 18'h0);
    chk("R8 read after stall", dataOut, A0);
    chk("R8 read oe after stall", 18'(dataOe), 18'd1);
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 2'b00, 6'h22, 18'h3FFFF);
    chk("R8 stall holds data", dataOut, A0);
    chk("R8 stall holds oe high", 18'(dataOe), 18'd1);
    step(1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 2'b00, 6'h00, 18'h0);
    chk("R9 deselect slot", 18'(dataOe), 18'd0);
    step(1'b1, 3'b000, 1'b1, 1'b0, 1'b0, 2'b00, 6'h22, 18'h0);
    step(1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 2'b00, 6'h00, 18'h0);
    chk("R8 stalled write ignored", dataOut, A0);

    // R10 output enable pin
    outEnN = 1'b1;
    #1;
    chk("R10 outEnN high blocks", 18'(dataOe), 18'd0);
    outEnN = 1'b0;
    #1;
    chk("R10 outEnN low drives", 18'(dataOe), 18'd1);

    // R1 reset with a read in flight
    step(1'b1, 3'b000, 1'b1, 1'b0, 1'b0, 2'b00, 6'h10, 18'h0);
    rstN = 1'b0;
    step(1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 2'b00, 6'h00, 18'h0);
    rstN = 1'b1;
    chk("R1 reset oe", 18'(dataOe), 18'd0);
    chk("R1 reset data", dataOut, 18'd0);
    step(1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 2'b00, 6'h00, 18'h0);
    chk("R1 flushed read", 18'(dataOe), 18'd0);

    finishRun();
  end
endmodule